// File: doc/BRIEF.md
# Path-Keyed State Machine with Interlocked Decoy State

This block is a small controller whose correct behaviour depends on the order of key portions it receives just after reset. It starts in a short startup region of three steps. Each step consumes one strobed key portion. Whatever the portions are, the machine always reaches the start of its functional region after the third strobe. The startup path only decides how the functional region behaves afterwards.

A one-bit path flag is built up during the startup steps. It is set only when every portion matched its expected value, in order. When the flag is clear, one functional transition is diverted into a decoy state. That state drives an illegal output pattern for a cycle and then drops the machine back to the first functional state. The design keeps running but produces wrong output sequences. When the flag is set, the decoy state cannot be reached.

The functional region is a four-state ring. It advances on a strobed input whose bit 0 is 1, and it drives a one-hot output for the current state. The correct key portions are a parameter, so no key storage lives inside the block.

Top module: `obf_interlock_fsm`

## Requirements
- R1: Synchronous reset puts the machine in startup step 0 (state code 3'b000), clears path_ok and drives func_out to 4'b0000.
- R2: In the startup region each cycle with key_vld high moves one step: code 3'b000 to 3'b001, 3'b001 to 3'b010, and 3'b010 to functional state F0 (code 3'b100). This happens for any key value. A cycle without key_vld holds the step.
- R3: After the third startup strobe, path_ok is 1 exactly when the portions were KEY_SEQ[KEY_W-1:0], then KEY_SEQ[2*KEY_W-1:KEY_W], then KEY_SEQ[3*KEY_W-1:2*KEY_W], in that order. Any mismatch gives 0.
- R4: path_ok does not change while the machine is in the functional region (codes 3'b011 to 3'b111).
- R5: In the functional region, a cycle with key_vld high and key_in[0] equal to 1 steps F0 (3'b100) to F1 (3'b101) to F2 (3'b110) to F3 (3'b111) and back to F0. Any other cycle holds the state, except for R7 and R8.
- R6: func_out is 4'b0000 in the startup region. In Fn it is one-hot with bit n set.
- R7: With path_ok at 0, a strobe with key_in[0] equal to 1 in F2 moves the machine to decoy state O3 (code 3'b011) instead of F3.
- R8: In O3, func_out is 4'b1111 for exactly one cycle. The next state is F0, whatever the inputs are.
- R9: With path_ok at 1, O3 is never entered, and a strobe with key_in[0] equal to 1 in F2 moves the machine to F3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | KEY_W | Key portion during startup; bit 0 is the step input in the functional region |
| key_vld | input | 1 | Strobe qualifying key_in |
| func_out | output | 4 | One-hot functional output, 4'b1111 in the decoy state |
| path_ok | output | 1 | Hidden flag: the correct startup path was followed |
| state | output | 3 | Current state code |

## Verification
The bench builds the block with KEY_W of 4 and KEY_SEQ of 12'hA5C, so the expected portions are 4'hC, then 4'h5, then 4'hA. With portions only four bits wide, random startup sequences that draw the expected value half of the time end on the correct path often enough. Both the unlocked ring and the diverted ring through O3 are therefore reached by the random episodes. Directed runs cover a mismatch at the first step and at the last step, startup holds between strobes, the decoy exit under an active strobe, and the unlocked pass through F2.

// File: rtl/obf_pkg.sv
package obf_pkg;

    localparam int PRE_STEPS = 3;
    localparam int FUNC_W    = 4;
    localparam logic [FUNC_W-1:0] DECOY_OUT = 4'b1111;
    localparam logic [2:0] FUNC_BASE = 3'b100;

    typedef enum logic [2:0] {
        ST_U0 = 3'b000,
        ST_U1 = 3'b001,
        ST_U2 = 3'b010,
        ST_O3 = 3'b011,
        ST_F0 = 3'b100,
        ST_F1 = 3'b101,
        ST_F2 = 3'b110,
        ST_F3 = 3'b111
    } obf_state_e;

    typedef struct packed {
        logic strobe;
        logic step;
    } func_in_t;

    function automatic logic is_startup(obf_state_e s);
        return (s == ST_U0) || (s == ST_U1) || (s == ST_U2);
    endfunction

    function automatic obf_state_e ring_next(obf_state_e s);
        case (s)
            ST_F0:   return ST_F1;
            ST_F1:   return ST_F2;
            ST_F2:   return ST_F3;
            default: return ST_F0;
        endcase
    endfunction

endpackage

// File: rtl/obf_preinit.sv
module obf_preinit
    import obf_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter logic [PRE_STEPS*KEY_W-1:0] KEY_SEQ = {8'h96, 8'h5A, 8'hC3}
) (
    input  logic             clk,
    input  logic             rst,
    input  obf_state_e       st,
    input  logic [KEY_W-1:0] key_in,
    input  logic             key_vld,
    output logic             in_pre,
    output obf_state_e       pre_nxt,
    output logic             ok_q
);

    logic [PRE_STEPS-1:0] step_hit;
    logic                 cur_hit;

    // one comparator per startup step against its expected portion
    for (genvar g = 0; g < PRE_STEPS; g++) begin : g_cmp
        assign step_hit[g] = (key_in == KEY_SEQ[g*KEY_W +: KEY_W]);
    end

    always_comb begin
        in_pre  = is_startup(st);
        cur_hit = 1'b0;
        pre_nxt = st;
        case (st)
            ST_U0: begin
                cur_hit = step_hit[0];
                if (key_vld) pre_nxt = ST_U1;
            end
            ST_U1: begin
                cur_hit = step_hit[1];
                if (key_vld) pre_nxt = ST_U2;
            end
            ST_U2: begin
                cur_hit = step_hit[2];
                if (key_vld) pre_nxt = ST_F0;
            end
            default: begin
                cur_hit = 1'b0;
                pre_nxt = st;
            end
        endcase
    end

    // first step seeds the flag; later steps can only clear it
    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q <= 1'b0;
        end else if (in_pre && key_vld) begin
            if (st == ST_U0) ok_q <= cur_hit;
            else             ok_q <= ok_q & cur_hit;
        end
    end

endmodule

// File: rtl/obf_func.sv
module obf_func
    import obf_pkg::*;
(
    input  obf_state_e st,
    input  func_in_t   fin,
    input  logic       unlocked,
    output obf_state_e func_nxt
);

    logic go;

    always_comb begin
        go       = fin.strobe & fin.step;
        func_nxt = st;
        case (st)
            ST_O3: func_nxt = ST_F0;
            ST_F2: begin
                if (go) func_nxt = unlocked ? ST_F3 : ST_O3;
            end
            ST_F0, ST_F1, ST_F3: begin
                if (go) func_nxt = ring_next(st);
            end
            default: func_nxt = st;
        endcase
    end

endmodule

// File: rtl/obf_outdec.sv
module obf_outdec
    import obf_pkg::*;
(
    input  obf_state_e        st,
    output logic [FUNC_W-1:0] func_out
);

    logic [FUNC_W-1:0] hot;

    for (genvar i = 0; i < FUNC_W; i++) begin : g_hot
        localparam logic [2:0] CODE = FUNC_BASE + 3'(i);
        assign hot[i] = (st == obf_state_e'(CODE));
    end

    assign func_out = (st == ST_O3) ? DECOY_OUT : hot;

endmodule

// File: rtl/obf_interlock_fsm.sv
module obf_interlock_fsm
    import obf_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter logic [PRE_STEPS*KEY_W-1:0] KEY_SEQ = {8'h96, 8'h5A, 8'hC3}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key_in,
    input  logic             key_vld,
    output logic [3:0]       func_out,
    output logic             path_ok,
    output logic [2:0]       state
);

    obf_state_e st_q;
    obf_state_e st_d;
    obf_state_e pre_nxt;
    obf_state_e func_nxt;
    logic       in_pre;
    logic       ok_q;
    func_in_t   fin;

    assign fin.strobe = key_vld;
    assign fin.step   = key_in[0];

    obf_preinit #(
        .KEY_W   (KEY_W),
        .KEY_SEQ (KEY_SEQ)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .st      (st_q),
        .key_in  (key_in),
        .key_vld (key_vld),
        .in_pre  (in_pre),
        .pre_nxt (pre_nxt),
        .ok_q    (ok_q)
    );

    obf_func u_func (
        .st       (st_q),
        .fin      (fin),
        .unlocked (ok_q),
        .func_nxt (func_nxt)
    );

    obf_outdec u_dec (
        .st       (st_q),
        .func_out (func_out)
    );

    assign st_d = in_pre ? pre_nxt : func_nxt;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_U0;
        else     st_q <= st_d;
    end

    assign path_ok = ok_q;
    assign state   = st_q;

endmodule

// File: rtl/obf_interlock_chk.sv
module obf_interlock_chk #(
    parameter int KEY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [KEY_W-1:0] key_in,
    input logic             key_vld,
    input logic [3:0]       func_out,
    input logic             path_ok,
    input logic [2:0]       state
);

    logic go;
    assign go = key_vld & key_in[0];

    p_rst_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == 3'b000 && !path_ok && func_out == 4'b0000));

    p_pre_step0_r2: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b000 && key_vld) |=> (state == 3'b001));

    p_pre_step1_r2: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b001 && key_vld) |=> (state == 3'b010));

    p_pre_step2_r2: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b010 && key_vld) |=> (state == 3'b100));

    p_pre_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state[2:1] != 2'b11 && state != 3'b011 && !key_vld) |=> $stable(state));

    p_ok_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (state[2] || state == 3'b011) |=> $stable(path_ok));

    p_func_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state[2] && !go) |=> $stable(state));

    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        state[2] |-> ($countones(func_out) == 1));

    p_divert_r7: assert property (@(posedge clk) disable iff (rst)
        (!path_ok && state == 3'b110 && go) |=> (state == 3'b011));

    p_decoy_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b011) |=> (state == 3'b100));

    p_decoy_out_r8: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b011) |-> (func_out == 4'b1111));

    p_no_decoy_r9: assert property (@(posedge clk) disable iff (rst)
        path_ok |-> (state != 3'b011));

endmodule

bind obf_interlock_fsm obf_interlock_chk #(.KEY_W(KEY_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .key_in   (key_in),
    .key_vld  (key_vld),
    .func_out (func_out),
    .path_ok  (path_ok),
    .state    (state)
);

// File: tb/obf_interlock_fsm_tb.sv
`timescale 1ns/1ps
module obf_interlock_fsm_tb;

    localparam int KW = 4;
    localparam logic [3*KW-1:0] KS = 12'hA5C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_vld = 1'b0;
    logic [KW-1:0] key_in = '0;
    logic [3:0]    func_out;
    logic          path_ok;
    logic [2:0]    state;

    int  n_chk = 0;
    int  n_fail = 0;
    int  m_st = 0;
    bit  m_ok = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    obf_interlock_fsm #(.KEY_W(KW), .KEY_SEQ(KS)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .key_in   (key_in),
        .key_vld  (key_vld),
        .func_out (func_out),
        .path_ok  (path_ok),
        .state    (state)
    );

    function automatic logic [KW-1:0] portion(int g);
        return KS[g*KW +: KW];
    endfunction

    function automatic int exp_out(int s);
        case (s)
            4: return 1;
            5: return 2;
            6: return 4;
            7: return 8;
            3: return 15;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock cycle: drive, update model at the edge, compare at negedge
    task automatic cyc(bit r, bit v, logic [KW-1:0] k);
        int    prev;
        string t_st;
        string t_ok;
        string t_out;
        prev = m_st;
        rst = r; key_vld = v; key_in = k;
        @(posedge clk);
        if (r) begin
            m_st = 0; m_ok = 1'b0;
        end else if (prev < 3) begin
            if (v) begin
                bit hit = (k == portion(prev));
                m_ok = (prev == 0) ? hit : (m_ok & hit);
                m_st = (prev == 2) ? 4 : prev + 1;
            end
        end else if (prev == 3) begin
            m_st = 4;
        end else if (v && k[0]) begin
            if (prev == 6) m_st = m_ok ? 7 : 3;
            else           m_st = (prev == 7) ? 4 : prev + 1;
        end
        @(negedge clk);
        t_st  = r ? "R1" : (prev < 3) ? "R2" : (prev == 3) ? "R8" : "R5";
        t_ok  = r ? "R1" : (prev < 3) ? "R3" : "R4";
        t_out = r ? "R1" : (m_st == 3) ? "R8" : "R6";
        check(t_st, "state", int'(state), m_st);
        check(t_ok, "path_ok", int'(path_ok), int'(m_ok));
        check(t_out, "func_out", int'(func_out), exp_out(m_st));
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0048));
        @(negedge clk);

        // R1: reset state
        cyc(1'b1, 1'b0, '0);
        cyc(1'b1, 1'b1, 4'hF);
        check("R1", "reset state", int'(state), 0);

        // R2/R3: correct path with idle gaps between strobes
        cyc(1'b0, 1'b1, portion(0));
        cyc(1'b0, 1'b0, portion(1));
        check("R2", "hold without strobe", int'(state), 1);
        cyc(1'b0, 1'b1, portion(1));
        cyc(1'b0, 1'b0, 4'h0);
        cyc(1'b0, 1'b1, portion(2));
        check("R2", "enter F0", int'(state), 4);
        check("R3", "unlocked flag", int'(path_ok), 1);

        // R5/R6/R9: ring walk unlocked
        cyc(1'b0, 1'b1, 4'h1);
        cyc(1'b0, 1'b1, 4'h0);
        check("R5", "hold on bit0=0", int'(state), 5);
        cyc(1'b0, 1'b0, 4'h1);
        check("R5", "hold without strobe", int'(state), 5);
        cyc(1'b0, 1'b1, 4'h3);
        cyc(1'b0, 1'b1, 4'h1);
        check("R9", "F2 advances to F3 when unlocked", int'(state), 7);
        check("R6", "F3 output", int'(func_out), 8);
        cyc(1'b0, 1'b1, 4'h1);
        check("R5", "wrap to F0", int'(state), 4);
        // R4: key-like values in functional region leave the flag alone
        cyc(1'b0, 1'b1, portion(0));
        check("R4", "flag stable", int'(path_ok), 1);

        // R3/R7/R8: mismatch at the last portion
        cyc(1'b1, 1'b0, '0);
        cyc(1'b0, 1'b1, portion(0));
        cyc(1'b0, 1'b1, portion(1));
        cyc(1'b0, 1'b1, portion(2) ^ 4'h2);
        check("R2", "wrong key still reaches F0", int'(state), 4);
        check("R3", "locked after last mismatch", int'(path_ok), 0);
        cyc(1'b0, 1'b1, 4'h1);
        cyc(1'b0, 1'b1, 4'h1);
        cyc(1'b0, 1'b1, 4'h1);
        check("R7", "diverted to O3", int'(state), 3);
        check("R8", "decoy output", int'(func_out), 15);
        cyc(1'b0, 1'b1, 4'h1);
        check("R8", "O3 exits to F0 under strobe", int'(state), 4);
        cyc(1'b0, 1'b1, 4'h1);
        cyc(1'b0, 1'b1, 4'h1);
        cyc(1'b0, 1'b1, 4'h1);
        cyc(1'b0, 1'b0, 4'h0);
        check("R8", "O3 exits to F0 idle", int'(state), 4);

        // R3: mismatch at the first portion only
        cyc(1'b1, 1'b0, '0);
        cyc(1'b0, 1'b1, portion(0) ^ 4'h8);
        cyc(1'b0, 1'b1, portion(1));
        cyc(1'b0, 1'b1, portion(2));
        check("R3", "locked after first mismatch", int'(path_ok), 0);

        // random episodes
        for (int ep = 0; ep < 60; ep++) begin
            cyc(1'b1, 1'b0, '0);
            for (int s = 0; s < 3; s++) begin
                if ($urandom % 4 == 0) cyc(1'b0, 1'b0, KW'($urandom));
                cyc(1'b0, 1'b1, ($urandom % 2 == 0) ? portion(s) : KW'($urandom));
            end
            for (int i = 0; i < 30; i++) begin
                cyc(1'b0, 1'($urandom % 4 != 0), KW'($urandom));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule